// File: doc/BRIEF.md
# Dual Latched Interval Timer

This block holds two 16-bit down-counters behind a byte-wide register window. The first timer has its own 16-bit reload latch and runs either once per load or continuously. In continuous mode it reloads from the latch after passing through the all-ones value. The second timer is loaded from its latch only by a write and always runs once. Both counters step only on a prescaled tick-enable input. Each counter reports a single-cycle flag-set pulse to a neighbouring interrupt unit. The block also emits single-cycle flag-clear requests on the register accesses that call for them. The interrupt flags themselves live outside this block.

Software writes the reload value one byte at a time. There are two ways to set the upper byte of the first timer's latch. One restarts the counter from the whole latch. The other only updates the latch and leaves the counter running, so the new value takes effect at the next continuous reload. The live counters can be read back a byte at a time. The mode of the first timer comes from bit 6 of an auxiliary control byte that is supplied as an input.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, both latches and both counters read 0xFFFF, and no flag-set pulse is issued until a timer is loaded. The only exception is continuous mode, which fires on every underflow.
- R2: A write to index 4 or to index 6 changes only the low byte of the first latch. The first counter is left as it was.
- R3: A write to index 5 sets the high byte of the first latch and pulses the first clear request in the same cycle. It also requests a load: at the next tick after the write cycle, the counter takes the full latch instead of decrementing.
- R4: A write to index 7 sets the high byte of the first latch and pulses the first clear request. The first counter is not reloaded.
- R5: A read of index 4 returns the first counter's low byte, and a read of index 5 returns its high byte. Only the index-4 read pulses the first clear request.
- R6: A read of index 6 returns the first latch's low byte, and a read of index 7 returns its high byte.
- R7: When bit 6 of the control byte is 1, the first timer is in continuous mode. It pulses its flag-set output on every tick that takes the counter from 0x0000 to 0xFFFF. On the tick after the counter reaches 0xFFFF it reloads from the latch, so the period is latch + 2 ticks.
- R8: When bit 6 of the control byte is 0, the first timer pulses its flag-set output only at the first 0x0000 to 0xFFFF tick after a load. It then keeps decrementing, through 0xFFFE and below, and stays silent until it is loaded again.
- R9: A write to index 8 sets the second latch's low byte. A write to index 9 sets its high byte, pulses the second clear request, and loads the second counter at the next tick. A read of index 8 or 9 returns the second counter's low or high byte, and only the index-8 read pulses the second clear request. The second timer fires once per load, in the same way as R8.
- R10: Neither counter changes in a cycle without a tick, except when reset is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled count enable |
| aux_ctrl | input | 8 | Auxiliary control byte; bit 6 selects continuous mode for the first timer |
| sel | input | 1 | Register access strobe, one cycle per access |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Register index, 4 to 9 decoded |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data during a read access, else zero |
| t1_set | output | 1 | First timer flag-set pulse |
| t2_set | output | 1 | Second timer flag-set pulse |
| t1_clr | output | 1 | First timer flag-clear request |
| t2_clr | output | 1 | Second timer flag-clear request |

## Verification
Two pairs of events can land on the same cycle. The first pair is a counter-restart write and a tick: the tick in that cycle still decrements, or applies an older pending load, and the new load waits for the following tick. The second pair is an update of the latch's upper byte and a continuous-mode reload from 0xFFFF: the reload takes the latch value from before that edge. The random phase keeps the tick dense and scatters writes to indices 5, 7 and 9, so these overlaps occur many times. A bench model applies the same edge ordering, and every read value and every pulse is compared with it cycle by cycle.

// File: rtl/dual_interval_timer.sv
module dual_interval_timer #(
  parameter int MODE_BIT = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [7:0] aux_ctrl,
  input  logic       sel,
  input  logic       wr,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       t1_set,
  output logic       t2_set,
  output logic       t1_clr,
  output logic       t2_clr
);
  localparam logic [15:0] ONES = 16'hFFFF;

  logic [15:0] lat1, lat2, cnt1, cnt2;
  logic        ld1, ld2, arm1, arm2;
  logic        wr_hit, rd_hit, free;

  assign wr_hit = sel & wr;
  assign rd_hit = sel & ~wr;
  assign free   = aux_ctrl[MODE_BIT];

  assign t1_set = tick & ~ld1 & (cnt1 == 16'h0000) & (free | arm1);
  assign t2_set = tick & ~ld2 & (cnt2 == 16'h0000) & arm2;

  assign t1_clr = (wr_hit & (addr == 4'd5 || addr == 4'd7)) | (rd_hit & addr == 4'd4);
  assign t2_clr = (wr_hit & addr == 4'd9) | (rd_hit & addr == 4'd8);

  always_comb begin
    rdata = 8'h00;
    if (rd_hit) begin
      case (addr)
        4'd4:    rdata = cnt1[7:0];
        4'd5:    rdata = cnt1[15:8];
        4'd6:    rdata = lat1[7:0];
        4'd7:    rdata = lat1[15:8];
        4'd8:    rdata = cnt2[7:0];
        4'd9:    rdata = cnt2[15:8];
        default: rdata = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat1 <= ONES;
      lat2 <= ONES;
    end else if (wr_hit) begin
      case (addr)
        4'd4, 4'd6: lat1[7:0]  <= wdata;
        4'd5, 4'd7: lat1[15:8] <= wdata;
        4'd8:       lat2[7:0]  <= wdata;
        4'd9:       lat2[15:8] <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt1 <= ONES;
      ld1  <= 1'b0;
      arm1 <= 1'b0;
    end else begin
      if (wr_hit && addr == 4'd5) ld1 <= 1'b1;
      else if (tick)              ld1 <= 1'b0;
      if (tick) begin
        if (ld1) begin
          cnt1 <= lat1;
          arm1 <= 1'b1;
        end else begin
          if (cnt1 == ONES && free) cnt1 <= lat1;
          else                      cnt1 <= cnt1 - 16'd1;
          if (t1_set) arm1 <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt2 <= ONES;
      ld2  <= 1'b0;
      arm2 <= 1'b0;
    end else begin
      if (wr_hit && addr == 4'd9) ld2 <= 1'b1;
      else if (tick)              ld2 <= 1'b0;
      if (tick) begin
        if (ld2) begin
          cnt2 <= lat2;
          arm2 <= 1'b1;
        end else begin
          cnt2 <= cnt2 - 16'd1;
          if (t2_set) arm2 <= 1'b0;
        end
      end
    end
  end

  a_r10_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(cnt1) && $stable(cnt2)));

  a_r7_reload_from_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && free && !ld1 && cnt1 == ONES) |=> (cnt1 == $past(lat1)));

  a_r8_set_then_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    t1_set |=> (cnt1 == ONES));

  a_r8_oneshot_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_set && !free) |=> !arm1);

  a_r9_t2_set_then_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    t2_set |=> (cnt2 == ONES));

  a_r4_latch_high_written: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == 4'd7) |=> (lat1[15:8] == $past(wdata)));

  a_r2_low_write_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == 4'd4 && !tick) |=> $stable(cnt1));
endmodule

// File: tb/sim_dual_interval_timer.sv
module sim_dual_interval_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [7:0] aux_ctrl = 8'h00;
  logic sel = 1'b0, wr = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic t1_set, t2_set, t1_clr, t2_clr;

  int total = 0, bad = 0, cyc = 0;
  int set1_cnt = 0, last_set = -1, prev_set = -1;
  logic [7:0] last_rd;

  logic [15:0] m_l1, m_l2, m_c1, m_c2;
  logic m_p1, m_p2, m_a1, m_a2;

  always #2 clk = ~clk;

  dual_interval_timer u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .aux_ctrl(aux_ctrl),
    .sel(sel), .wr(wr), .addr(addr), .wdata(wdata), .rdata(rdata),
    .t1_set(t1_set), .t2_set(t2_set), .t1_clr(t1_clr), .t2_clr(t2_clr));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [3:0] a);
    case (a)
      4'd4: return m_c1[7:0];
      4'd5: return m_c1[15:8];
      4'd6: return m_l1[7:0];
      4'd7: return m_l1[15:8];
      4'd8: return m_c2[7:0];
      4'd9: return m_c2[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_reset();
    m_l1 = 16'hFFFF; m_l2 = 16'hFFFF; m_c1 = 16'hFFFF; m_c2 = 16'hFFFF;
    m_p1 = 0; m_p2 = 0; m_a1 = 0; m_a2 = 0;
  endtask

  task automatic step(input logic tk, input logic s, input logic w,
                      input logic [3:0] a, input logic [7:0] d);
    logic free, e1, e2, c1, c2;
    logic [15:0] ol1, ol2;
    @(negedge clk);
    tick = tk; sel = s; wr = w; addr = a; wdata = d;
    #1;
    free = aux_ctrl[6];
    e1 = tk && !m_p1 && m_c1 == 16'h0 && (free || m_a1);
    e2 = tk && !m_p2 && m_c2 == 16'h0 && m_a2;
    c1 = (s && w && (a == 4'd5 || a == 4'd7)) || (s && !w && a == 4'd4);
    c2 = (s && w && a == 4'd9) || (s && !w && a == 4'd8);
    chk(free ? "R7 t1_set" : "R8 t1_set", int'(t1_set), int'(e1));
    chk("R9 t2_set", int'(t2_set), int'(e2));
    chk(w ? "R3/R4 t1_clr" : "R5 t1_clr", int'(t1_clr), int'(c1));
    chk("R9 t2_clr", int'(t2_clr), int'(c2));
    if (s && !w) begin
      if (a == 4'd4 || a == 4'd5) chk("R5 read", int'(rdata), int'(m_read(a)));
      else if (a == 4'd6 || a == 4'd7) chk("R6 read", int'(rdata), int'(m_read(a)));
      else chk("R9 read", int'(rdata), int'(m_read(a)));
      last_rd = rdata;
    end
    if (t1_set) begin set1_cnt++; prev_set = last_set; last_set = cyc; end
    ol1 = m_l1; ol2 = m_l2;
    if (tk) begin
      if (m_p1) begin m_c1 = ol1; m_a1 = 1; end
      else begin
        m_c1 = (m_c1 == 16'hFFFF && free) ? ol1 : m_c1 - 16'd1;
        if (e1) m_a1 = 0;
      end
      if (m_p2) begin m_c2 = ol2; m_a2 = 1; end
      else begin
        m_c2 = m_c2 - 16'd1;
        if (e2) m_a2 = 0;
      end
    end
    if (s && w && a == 4'd5) m_p1 = 1; else if (tk) m_p1 = 0;
    if (s && w && a == 4'd9) m_p2 = 1; else if (tk) m_p2 = 0;
    if (s && w) begin
      case (a)
        4'd4, 4'd6: m_l1[7:0] = d;
        4'd5, 4'd7: m_l1[15:8] = d;
        4'd8: m_l2[7:0] = d;
        4'd9: m_l2[15:8] = d;
        default: ;
      endcase
    end
    cyc++;
  endtask

  task automatic rd(input logic tk, input logic [3:0] a);
    step(tk, 1'b1, 1'b0, a, 8'h00);
  endtask

  task automatic wrr(input logic tk, input logic [3:0] a, input logic [7:0] d);
    step(tk, 1'b1, 1'b1, a, d);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [7:0] h0, h1;
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 4; i <= 9; i++) begin
      rd(1'b0, 4'(i));
      chk("R1 reset value", int'(last_rd), 8'hFF);
    end

    wrr(1'b0, 4'd4, 8'h12);
    rd(1'b0, 4'd6); chk("R2 latch low", int'(last_rd), 8'h12);
    rd(1'b0, 4'd4); chk("R2 counter kept", int'(last_rd), 8'hFF);
    wrr(1'b0, 4'd7, 8'h34);
    step(1'b1, 1'b0, 1'b0, 4'd0, 8'h00);
    rd(1'b0, 4'd5); chk("R4 no reload", int'(last_rd), 8'hFF);
    rd(1'b0, 4'd7); chk("R4 latch high", int'(last_rd), 8'h34);
    rd(1'b0, 4'd4); h0 = last_rd;
    repeat (5) step(1'b0, 1'b0, 1'b0, 4'd0, 8'h00);
    rd(1'b0, 4'd4); chk("R10 hold without tick", int'(last_rd), int'(h0));

    aux_ctrl = 8'h40;
    wrr(1'b0, 4'd6, 8'h03);
    wrr(1'b0, 4'd5, 8'h00);
    step(1'b1, 1'b0, 1'b0, 4'd0, 8'h00);
    rd(1'b0, 4'd4); chk("R3 loaded at tick", int'(last_rd), 8'h03);
    set1_cnt = 0;
    repeat (30) step(1'b1, 1'b0, 1'b0, 4'd0, 8'h00);
    chk("R7 period latch+2", last_set - prev_set, 5);
    chk("R7 set count", set1_cnt, 6);

    aux_ctrl = 8'h00;
    wrr(1'b0, 4'd6, 8'h02);
    wrr(1'b0, 4'd5, 8'h00);
    set1_cnt = 0;
    repeat (20) step(1'b1, 1'b0, 1'b0, 4'd0, 8'h00);
    chk("R8 single set", set1_cnt, 1);
    rd(1'b0, 4'd5); chk("R8 keeps counting", int'(last_rd), 8'hFF);

    wrr(1'b0, 4'd8, 8'h01);
    wrr(1'b0, 4'd9, 8'h00);
    step(1'b1, 1'b0, 1'b0, 4'd0, 8'h00);
    rd(1'b0, 4'd8); chk("R9 t2 loaded", int'(last_rd), 8'h01);
    rd(1'b0, 4'd9); h1 = last_rd; chk("R9 t2 high", int'(h1), 8'h00);

    for (int n = 0; n < 6000; n++) begin
      logic tk, s, w;
      logic [3:0] a;
      if (n % 1500 == 0) aux_ctrl = ($urandom % 2) ? 8'h40 : 8'h00;
      tk = ($urandom % 4) != 0;
      s  = ($urandom % 3) == 0;
      w  = $urandom % 2;
      a  = 4'(4 + ($urandom % 6));
      if (s && w && (a == 4'd5 || a == 4'd9 || a == 4'd7))
        step(tk, s, w, a, 8'($urandom % 2));
      else
        step(tk, s, w, a, 8'($urandom % 8));
    end
    finish_run();
  end
endmodule